// File: doc/BRIEF.md
# Microcoded Multicycle Control Sequencer

This block is the control unit of a small 32-bit multicycle load/store processor. A micro-address register selects one 16-bit word from a constant microcode store. The fields of that word are decoded into the strobes and selects that steer the datapath. These cover the ALU operation and operand muxes, register-file write, memory access, instruction-register load, PC update and exception capture. All control outputs are combinational from the current micro-address, plus the ALU zero flag for the conditional PC write.

Each word carries a 2-bit sequencing field that picks the next micro-address. The choices are: return to the fetch word, jump through a dispatch table indexed by the 6-bit opcode, or step to the next word. The first R-type execute word has one extra path: if the ALU reports overflow in that cycle, the sequencer goes to an overflow trap word instead of stepping. Opcodes with no defined sequence dispatch to an undefined-instruction trap word. Both trap words raise a capture strobe with a cause code for one cycle and then return to fetch.

Top module: `mseq_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, the outputs show the fetch word: alu_op 00 (add), sel_a 0 (PC), sel_b 001 (constant 4), mem_rd 1 with iord 0, ir_wr 1, pc_wr 1 with pc_src 00 (ALU). All other strobes are 0. An asynchronous reset in mid-sequence returns the outputs to fetch at once.
- R2: The cycle after fetch is decode: alu_op 00, sel_a 0, sel_b 011 (sign-extended offset shifted by 2), target_wr 1. No memory, register or PC strobe is set.
- R3: Decode dispatches on opcode_i. The defined opcodes are 000000 R-type, 100011 load, 101011 store, 001101 OR-immediate, 000100 branch-if-equal and 000010 jump.
- R4: Branch-if-equal takes one cycle with alu_op 01 (subtract), sel_a 1, sel_b 000, pc_wr_cond 1 and pc_src 01 (target). pc_wr is 1 only when zero_i is 1. The next cycle is fetch.
- R5: Jump takes one cycle with pc_wr 1 and pc_src 10. ALU fields are zero and all other strobes are 0. The next cycle is fetch.
- R6: R-type takes two cycles of alu_op 10 (function code), sel_a 1, sel_b 000. The second cycle sets reg_wr 1, reg_dst 1 and mem_to_reg 0. The next cycle is fetch.
- R7: OR-immediate takes two cycles of alu_op 11, sel_a 1, sel_b 100 (zero-extended). The second cycle sets reg_wr 1 with reg_dst 0. The next cycle is fetch.
- R8: Load takes three cycles of alu_op 00, sel_a 1, sel_b 010. The second cycle sets mem_rd 1 and iord 1. The third sets reg_wr 1, mem_to_reg 1 and reg_dst 0. The next cycle is fetch.
- R9: Store takes two cycles of alu_op 00, sel_a 1, sel_b 010. The second cycle sets mem_wr 1 and iord 1. The next cycle is fetch.
- R10: An undefined opcode at decode leads to one cycle with exc 1 and exc_cause 10. ALU fields are zero and all other strobes are 0. The next cycle is fetch.
- R11: ovf_i high in the first R-type cycle replaces the second R-type cycle with one cycle of exc 1 and exc_cause 12, with no register write. The next cycle is fetch. ovf_i in any other cycle has no effect.
- R12: exc is 0 and exc_cause is 0 in every cycle that is not a trap cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| opcode_i | input | 6 | Instruction opcode, used at decode |
| zero_i | input | 1 | ALU zero flag |
| ovf_i | input | 1 | ALU overflow flag |
| alu_op_o | output | 2 | 00 add, 01 sub, 10 function code, 11 OR |
| alu_sel_a_o | output | 1 | First operand: 0 PC, 1 register rs |
| alu_sel_b_o | output | 3 | Second operand select |
| reg_wr_o | output | 1 | Register file write |
| mem_to_reg_o | output | 1 | Write data from memory |
| reg_dst_o | output | 1 | Destination: 0 rt, 1 rd |
| target_wr_o | output | 1 | Load branch target register |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| iord_o | output | 1 | Memory address: 0 PC, 1 ALU |
| ir_wr_o | output | 1 | Instruction register load |
| pc_wr_o | output | 1 | PC write (conditional one already gated by zero) |
| pc_wr_cond_o | output | 1 | Conditional PC write requested |
| pc_src_o | output | 2 | PC source select |
| exc_o | output | 1 | Exception capture strobe |
| exc_cause_o | output | 5 | Exception cause code |

## Verification
The control word of a micro-state appears as soon as the micro-address register takes that state, one clock edge after the state before it. The one exception is pc_wr, which also follows zero_i in the same cycle. So an opcode presented during decode shows its first sequence word one edge later. Overflow raised in the first R-type cycle shows the trap one edge later, and every sequence is back at fetch one edge after its last word. The bench changes inputs just after the falling edge and compares the whole output vector a moment later. This places each check one edge after the stimulus that caused it, and never at an edge.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int UA_W    = 4;
  localparam int OP_W    = 6;
  localparam int CAUSE_W = 5;

  typedef logic [UA_W-1:0] uaddr_t;

  localparam logic [1:0] ALU_ADD = 2'b00, ALU_SUB = 2'b01, ALU_FUN = 2'b10, ALU_OR = 2'b11;
  localparam logic [2:0] B_RT = 3'b000, B_FOUR = 3'b001, B_SX = 3'b010, B_SXSH = 3'b011, B_ZX = 3'b100;
  localparam logic [1:0] D_NONE = 2'b00, D_TGT = 2'b01, D_RD = 2'b10, D_RT = 2'b11;
  localparam logic [2:0] M_NONE = 3'b000, M_RD_PC = 3'b001, M_RD_ALU = 3'b010,
                         M_WR_ALU = 3'b011, M_LD_RT = 3'b100;
  localparam logic [1:0] P_NONE = 2'b00, P_ALU = 2'b01, P_COND = 2'b10, P_JMP = 2'b11;
  localparam logic [1:0] S_FETCH = 2'b00, S_DISP = 2'b01, S_INC = 2'b10;

  localparam uaddr_t UA_FETCH = 4'd0,  UA_DECODE = 4'd1,  UA_BEQ    = 4'd2,  UA_JUMP   = 4'd3;
  localparam uaddr_t UA_RT_EX = 4'd4,  UA_RT_WB  = 4'd5,  UA_ORI_EX = 4'd6,  UA_ORI_WB = 4'd7;
  localparam uaddr_t UA_LW_AD = 4'd8,  UA_LW_MEM = 4'd9,  UA_LW_WB  = 4'd10, UA_SW_AD  = 4'd11;
  localparam uaddr_t UA_SW_MEM = 4'd12, UA_UNDEF = 4'd13, UA_OVF    = 4'd14;

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000, OPC_LW = 6'b100011, OPC_SW = 6'b101011,
                              OPC_ORI = 6'b001101, OPC_BEQ = 6'b000100, OPC_J = 6'b000010;

  localparam logic [CAUSE_W-1:0] CAUSE_RI = 5'd10, CAUSE_OVF = 5'd12;

  typedef struct packed {
    logic [1:0] alu;
    logic       src1;
    logic [2:0] src2;
    logic [1:0] dest;
    logic [2:0] mem;
    logic       irw;
    logic [1:0] pcw;
    logic [1:0] seq;
  } uinst_t;

  function automatic uinst_t uop(logic [1:0] alu, logic s1, logic [2:0] s2, logic [1:0] d,
                                 logic [2:0] m, logic irw, logic [1:0] pcw, logic [1:0] sq);
    uop = '{alu: alu, src1: s1, src2: s2, dest: d, mem: m, irw: irw, pcw: pcw, seq: sq};
  endfunction
endpackage

// File: rtl/mseq_rom.sv
module mseq_rom
  import mseq_pkg::*;
(
  input  uaddr_t upc_i,
  output uinst_t word_o
);
  always_comb begin
    unique case (upc_i)
      UA_FETCH:  word_o = uop(ALU_ADD, 1'b0, B_FOUR, D_NONE, M_RD_PC,  1'b1, P_ALU,  S_INC);
      UA_DECODE: word_o = uop(ALU_ADD, 1'b0, B_SXSH, D_TGT,  M_NONE,   1'b0, P_NONE, S_DISP);
      UA_BEQ:    word_o = uop(ALU_SUB, 1'b1, B_RT,   D_NONE, M_NONE,   1'b0, P_COND, S_FETCH);
      UA_JUMP:   word_o = uop(ALU_ADD, 1'b0, B_RT,   D_NONE, M_NONE,   1'b0, P_JMP,  S_FETCH);
      UA_RT_EX:  word_o = uop(ALU_FUN, 1'b1, B_RT,   D_NONE, M_NONE,   1'b0, P_NONE, S_INC);
      UA_RT_WB:  word_o = uop(ALU_FUN, 1'b1, B_RT,   D_RD,   M_NONE,   1'b0, P_NONE, S_FETCH);
      UA_ORI_EX: word_o = uop(ALU_OR,  1'b1, B_ZX,   D_NONE, M_NONE,   1'b0, P_NONE, S_INC);
      UA_ORI_WB: word_o = uop(ALU_OR,  1'b1, B_ZX,   D_RT,   M_NONE,   1'b0, P_NONE, S_FETCH);
      UA_LW_AD:  word_o = uop(ALU_ADD, 1'b1, B_SX,   D_NONE, M_NONE,   1'b0, P_NONE, S_INC);
      UA_LW_MEM: word_o = uop(ALU_ADD, 1'b1, B_SX,   D_NONE, M_RD_ALU, 1'b0, P_NONE, S_INC);
      UA_LW_WB:  word_o = uop(ALU_ADD, 1'b1, B_SX,   D_NONE, M_LD_RT,  1'b0, P_NONE, S_FETCH);
      UA_SW_AD:  word_o = uop(ALU_ADD, 1'b1, B_SX,   D_NONE, M_NONE,   1'b0, P_NONE, S_INC);
      UA_SW_MEM: word_o = uop(ALU_ADD, 1'b1, B_SX,   D_NONE, M_WR_ALU, 1'b0, P_NONE, S_FETCH);
      default:   word_o = uop(ALU_ADD, 1'b0, B_RT,   D_NONE, M_NONE,   1'b0, P_NONE, S_FETCH);
    endcase
  end
endmodule

// File: rtl/mseq_dispatch.sv
module mseq_dispatch
  import mseq_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output uaddr_t          target_o
);
  always_comb begin
    unique case (opcode_i)
      OPC_RTYPE: target_o = UA_RT_EX;
      OPC_LW:    target_o = UA_LW_AD;
      OPC_SW:    target_o = UA_SW_AD;
      OPC_ORI:   target_o = UA_ORI_EX;
      OPC_BEQ:   target_o = UA_BEQ;
      OPC_J:     target_o = UA_JUMP;
      default:   target_o = UA_UNDEF;
    endcase
  end
endmodule

// File: rtl/mseq_next.sv
module mseq_next
  import mseq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] seq_i,
  input  uaddr_t     disp_i,
  input  logic       ovf_i,
  output uaddr_t     upc_o
);
  uaddr_t upc_q, upc_d;

  always_comb begin
    unique case (seq_i)
      S_DISP:  upc_d = disp_i;
      S_INC:   upc_d = upc_q + uaddr_t'(1);
      default: upc_d = UA_FETCH;
    endcase
    // overflow is only sampled in the first R-type word
    if (upc_q == UA_RT_EX && ovf_i) upc_d = UA_OVF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upc_q <= UA_FETCH;
    else         upc_q <= upc_d;
  end

  assign upc_o = upc_q;
endmodule

// File: rtl/mseq_decode.sv
module mseq_decode
  import mseq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  uaddr_t              upc_i,
  input  logic [1:0]          dest_i,
  input  logic [2:0]          mem_i,
  input  logic [1:0]          pcw_i,
  input  logic                zero_i,
  output logic                reg_wr_o,
  output logic                mem_to_reg_o,
  output logic                reg_dst_o,
  output logic                target_wr_o,
  output logic                mem_rd_o,
  output logic                mem_wr_o,
  output logic                iord_o,
  output logic                pc_wr_o,
  output logic                pc_wr_cond_o,
  output logic [1:0]          pc_src_o,
  output logic                exc_o,
  output logic [CAUSE_W-1:0]  exc_cause_o
);
  logic pc_uncond;

  always_comb begin
    target_wr_o  = (dest_i == D_TGT);
    reg_dst_o    = (dest_i == D_RD);
    mem_to_reg_o = (mem_i == M_LD_RT);
    reg_wr_o     = (dest_i == D_RD) || (dest_i == D_RT) || mem_to_reg_o;
    mem_rd_o     = (mem_i == M_RD_PC) || (mem_i == M_RD_ALU);
    mem_wr_o     = (mem_i == M_WR_ALU);
    iord_o       = (mem_i == M_RD_ALU) || (mem_i == M_WR_ALU);
  end

  always_comb begin
    pc_uncond    = 1'b0;
    pc_wr_cond_o = 1'b0;
    pc_src_o     = 2'b00;
    unique case (pcw_i)
      P_ALU:   pc_uncond = 1'b1;
      P_COND:  begin pc_wr_cond_o = 1'b1; pc_src_o = 2'b01; end
      P_JMP:   begin pc_uncond = 1'b1; pc_src_o = 2'b10; end
      default: ;
    endcase
    pc_wr_o = pc_uncond || (pc_wr_cond_o && zero_i);
  end

  always_comb begin
    exc_o       = 1'b0;
    exc_cause_o = '0;
    if (upc_i == UA_UNDEF) begin exc_o = 1'b1; exc_cause_o = CAUSE_RI;  end
    if (upc_i == UA_OVF)   begin exc_o = 1'b1; exc_cause_o = CAUSE_OVF; end
  end

  // R4
  beq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_wr_cond_o && !zero_i) |-> !pc_wr_o);
  // R8
  mem_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_rd_o, mem_wr_o, mem_to_reg_o}));
  // R12
  exc_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> !(reg_wr_o || mem_rd_o || mem_wr_o || pc_wr_o || target_wr_o));
endmodule

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
  import mseq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [OP_W-1:0]     opcode_i,
  input  logic                zero_i,
  input  logic                ovf_i,
  output logic [1:0]          alu_op_o,
  output logic                alu_sel_a_o,
  output logic [2:0]          alu_sel_b_o,
  output logic                reg_wr_o,
  output logic                mem_to_reg_o,
  output logic                reg_dst_o,
  output logic                target_wr_o,
  output logic                mem_rd_o,
  output logic                mem_wr_o,
  output logic                iord_o,
  output logic                ir_wr_o,
  output logic                pc_wr_o,
  output logic                pc_wr_cond_o,
  output logic [1:0]          pc_src_o,
  output logic                exc_o,
  output logic [CAUSE_W-1:0]  exc_cause_o
);
  uaddr_t upc, disp;
  uinst_t word;

  mseq_rom u_rom (.upc_i(upc), .word_o(word));

  mseq_dispatch u_disp (.opcode_i(opcode_i), .target_o(disp));

  mseq_next u_next (
    .clk_i(clk_i), .rst_ni(rst_ni), .seq_i(word.seq),
    .disp_i(disp), .ovf_i(ovf_i), .upc_o(upc)
  );

  mseq_decode u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .upc_i(upc),
    .dest_i(word.dest), .mem_i(word.mem), .pcw_i(word.pcw), .zero_i(zero_i),
    .reg_wr_o(reg_wr_o), .mem_to_reg_o(mem_to_reg_o), .reg_dst_o(reg_dst_o),
    .target_wr_o(target_wr_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .iord_o(iord_o), .pc_wr_o(pc_wr_o), .pc_wr_cond_o(pc_wr_cond_o),
    .pc_src_o(pc_src_o), .exc_o(exc_o), .exc_cause_o(exc_cause_o)
  );

  assign alu_op_o    = word.alu;
  assign alu_sel_a_o = word.src1;
  assign alu_sel_b_o = word.src2;
  assign ir_wr_o     = word.irw;

  // R2
  fetch_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_wr_o |=> (target_wr_o && !ir_wr_o));
  // R10
  exc_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |=> (ir_wr_o && mem_rd_o && !exc_o));
  // R11
  ovf_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_op_o == ALU_FUN && !reg_wr_o && ovf_i) |=> (exc_o && exc_cause_o == CAUSE_OVF));
endmodule

// File: tb/mseq_ctrl_tb.sv
module mseq_ctrl_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [5:0] opcode = '0;
  logic zero = 1'b0, ovf = 1'b0;
  logic [1:0] alu_op, pc_src;
  logic sel_a, reg_wr, m2r, dst, tw, mrd, mwr, iord, irw, pcw, pcwc, exc;
  logic [2:0] sel_b;
  logic [4:0] cause;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  mseq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .opcode_i(opcode), .zero_i(zero), .ovf_i(ovf),
    .alu_op_o(alu_op), .alu_sel_a_o(sel_a), .alu_sel_b_o(sel_b), .reg_wr_o(reg_wr),
    .mem_to_reg_o(m2r), .reg_dst_o(dst), .target_wr_o(tw), .mem_rd_o(mrd),
    .mem_wr_o(mwr), .iord_o(iord), .ir_wr_o(irw), .pc_wr_o(pcw), .pc_wr_cond_o(pcwc),
    .pc_src_o(pc_src), .exc_o(exc), .exc_cause_o(cause)
  );

  wire [23:0] got = {alu_op, sel_a, sel_b, reg_wr, m2r, dst, tw, mrd, mwr, iord, irw,
                     pcw, pcwc, pc_src, exc, cause};

  // wr = {reg_wr, mem_to_reg, reg_dst, target_wr}; m = {mem_rd, mem_wr, iord}
  // pc = {pc_wr, pc_wr_cond, pc_src}; ex = {exc, cause}
  function automatic logic [23:0] sg(logic [1:0] alu, logic a, logic [2:0] b, logic [3:0] wr,
                                     logic [2:0] m, logic ir, logic [3:0] pc, logic [5:0] ex);
    sg = {alu, a, b, wr, m, ir, pc, ex};
  endfunction

  localparam logic [23:0] E_FETCH  = sg(2'b00, 1'b0, 3'b001, 4'b0000, 3'b100, 1'b1, 4'b1000, 6'd0);
  localparam logic [23:0] E_DECODE = sg(2'b00, 1'b0, 3'b011, 4'b0001, 3'b000, 1'b0, 4'b0000, 6'd0);
  localparam logic [23:0] E_JUMP   = sg(2'b00, 1'b0, 3'b000, 4'b0000, 3'b000, 1'b0, 4'b1010, 6'd0);
  localparam logic [23:0] E_R_EX   = sg(2'b10, 1'b1, 3'b000, 4'b0000, 3'b000, 1'b0, 4'b0000, 6'd0);
  localparam logic [23:0] E_R_WB   = sg(2'b10, 1'b1, 3'b000, 4'b1010, 3'b000, 1'b0, 4'b0000, 6'd0);
  localparam logic [23:0] E_OR_EX  = sg(2'b11, 1'b1, 3'b100, 4'b0000, 3'b000, 1'b0, 4'b0000, 6'd0);
  localparam logic [23:0] E_OR_WB  = sg(2'b11, 1'b1, 3'b100, 4'b1000, 3'b000, 1'b0, 4'b0000, 6'd0);
  localparam logic [23:0] E_ADR    = sg(2'b00, 1'b1, 3'b010, 4'b0000, 3'b000, 1'b0, 4'b0000, 6'd0);
  localparam logic [23:0] E_LW_MEM = sg(2'b00, 1'b1, 3'b010, 4'b0000, 3'b101, 1'b0, 4'b0000, 6'd0);
  localparam logic [23:0] E_LW_WB  = sg(2'b00, 1'b1, 3'b010, 4'b1100, 3'b000, 1'b0, 4'b0000, 6'd0);
  localparam logic [23:0] E_SW_MEM = sg(2'b00, 1'b1, 3'b010, 4'b0000, 3'b011, 1'b0, 4'b0000, 6'd0);
  localparam logic [23:0] E_UNDEF  = sg(2'b00, 1'b0, 3'b000, 4'b0000, 3'b000, 1'b0, 4'b0000, {1'b1, 5'd10});
  localparam logic [23:0] E_OVF    = sg(2'b00, 1'b0, 3'b000, 4'b0000, 3'b000, 1'b0, 4'b0000, {1'b1, 5'd12});

  function automatic logic [23:0] e_beq(logic z);
    e_beq = sg(2'b01, 1'b1, 3'b000, 4'b0000, 3'b000, 1'b0, {z, 1'b1, 2'b01}, 6'd0);
  endfunction

  task automatic chk(input logic [23:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
    #1;
  endtask

  // starts in fetch, ends in the first dispatched word
  task automatic fetch_decode(input logic [5:0] op, input string tag);
    opcode = op;
    chk(E_FETCH, {tag, " R1 fetch"});
    step();
    chk(E_DECODE, {tag, " R2 decode"});
    step();
    opcode = 6'b111111;
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(E_FETCH, "R1 in reset");
    rst_ni = 1'b1;
    #1;
    chk(E_FETCH, "R1 after release");
  endtask

  task automatic t_reset_mid;
    fetch_decode(6'b100011, "R1 mid");
    chk(E_ADR, "R8 before mid reset");
    rst_ni = 1'b0;
    #1;
    chk(E_FETCH, "R1 async mid-sequence");
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
  endtask

  task automatic t_beq(input logic z);
    fetch_decode(6'b000100, "R3 beq");
    zero = z;
    #1;
    chk(e_beq(z), z ? "R4 beq taken" : "R4 beq not taken");
    step();
    zero = 1'b0;
    chk(E_FETCH, "R4 beq return");
  endtask

  task automatic t_jump;
    fetch_decode(6'b000010, "R3 jump");
    chk(E_JUMP, "R5 jump");
    step();
    chk(E_FETCH, "R5 jump return");
  endtask

  task automatic t_rtype(input logic late_ovf);
    fetch_decode(6'b000000, "R3 rtype");
    chk(E_R_EX, "R6 rtype ex");
    step();
    ovf = late_ovf;
    #1;
    chk(E_R_WB, late_ovf ? "R11 late ovf ignored" : "R6 rtype wb");
    step();
    ovf = 1'b0;
    chk(E_FETCH, "R6 rtype return");
  endtask

  task automatic t_rtype_ovf;
    fetch_decode(6'b000000, "R3 rtype ovf");
    ovf = 1'b1;
    #1;
    chk(E_R_EX, "R11 ex with ovf");
    step();
    ovf = 1'b0;
    chk(E_OVF, "R11 overflow trap");
    step();
    chk(E_FETCH, "R11 trap return");
  endtask

  task automatic t_ori;
    fetch_decode(6'b001101, "R3 ori");
    chk(E_OR_EX, "R7 ori ex");
    step();
    chk(E_OR_WB, "R7 ori wb");
    step();
    chk(E_FETCH, "R7 ori return");
  endtask

  task automatic t_lw;
    ovf = 1'b1;
    fetch_decode(6'b100011, "R3 lw");
    chk(E_ADR, "R8 lw addr (ovf high, R11 ignored)");
    step();
    chk(E_LW_MEM, "R8 lw mem");
    step();
    chk(E_LW_WB, "R8 lw wb");
    step();
    ovf = 1'b0;
    chk(E_FETCH, "R8 lw return");
  endtask

  task automatic t_sw;
    fetch_decode(6'b101011, "R3 sw");
    chk(E_ADR, "R9 sw addr");
    step();
    chk(E_SW_MEM, "R9 sw mem");
    step();
    chk(E_FETCH, "R9 sw return");
  endtask

  task automatic t_undef(input logic [5:0] op);
    fetch_decode(op, "R3 undef");
    chk(E_UNDEF, "R10 undefined trap");
    step();
    chk(E_FETCH, "R10 trap return (R12 exc cleared)");
  endtask

  initial begin
    #(CLK_P * 5000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_rtype(1'b0);
    t_rtype(1'b1);
    t_rtype_ovf();
    t_ori();
    t_lw();
    t_sw();
    t_beq(1'b1);
    t_beq(1'b0);
    t_jump();
    t_undef(6'b111111);
    t_undef(6'b000001);
    t_undef(6'b100010);
    t_reset_mid();
    t_jump();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule